// File: doc/BRIEF.md
# Read-Then-Clear Interrupt Status Flag Bank

This block holds a bank of interrupt status flags for a timer unit. Each flag is set by a single-cycle hardware event pulse, and each flag drives its own interrupt request line. A bus master clears a flag in two steps. It first reads the register while the flag is 1, which arms that bit. It then writes 0 to that bit. A write of 0 to a bit that was never read as 1 does nothing, so a flag that was raised after software last looked at it cannot be lost.

The flags fall into two groups, chosen by a parameter mask. In the retry group, an event that reaches an armed bit before the write of 0 turns that write into a no-op, and software must read again before a clear takes effect. In the plain group, the repeat event is absorbed into the flag that is already set, and the write of 0 still clears the flag.

A DMA engine that services a flag sends an acknowledge with the flag index and the source and destination addresses of its transfer. The flag is cleared by hardware only when at least one of the two addresses lies inside the timer's I/O window. Otherwise the flag stays set, and software has to clear it with the normal read-then-write sequence.

Top module: `irq_status_bank`

## Requirements
- R1: After reset every flag is 0, so `busRdata` and `irqOut` are all zeros.
- R2: An event pulse on `evtIn[i]` sets flag i at the next clock edge. Bit i of `busRdata` and `irqOut[i]` both show flag i, and an event on a bit that is already set leaves it set.
- R3: Writing 1 to a flag bit never changes that flag. Only event inputs can set a flag.
- R4: A write of 0 to a set flag that has not been read as 1 since the last write to the register leaves the flag set.
- R5: If a flag is read as 1 (`busRead` high) and 0 is then written to it in a later cycle with no event in between, the flag is 0 from the edge that ends the write cycle.
- R6: For a bit in the retry group (bits set in `RETRY_MASK`, default 0xFF00 = bits 8 to 15), an event that arrives after the arming read and before the write of 0 makes that write have no effect. A fresh read of 1 followed by a write of 0 then clears the flag.
- R7: For a bit in the plain group (default bits 0 to 7), an event that arrives between the arming read and the write of 0 does not stop the write of 0 from clearing the flag.
- R8: Any write to the register disarms every bit, whether or not it cleared anything. A write of 1 after the read therefore uses up the arm, and a following write of 0 leaves the flag set.
- R9: If an event on bit i arrives in the same cycle as a valid clear of bit i (by bus write or by DMA), the flag stays set.
- R10: A DMA acknowledge for flag `dmaIdx` clears that flag at the next edge when the source or the destination address lies in 0xFFFF8200 to 0xFFFF82FF, with both ends included. The clear also disarms that bit.
- R11: A DMA acknowledge whose source and destination addresses both lie outside that window changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRead | input | 1 | Register read strobe; arms every bit that is currently 1 |
| busWrite | input | 1 | Register write strobe |
| busWdata | input | NUM_FLAGS | Write data; a 0 requests a clear of the matching armed bit |
| busRdata | output | NUM_FLAGS | Current flag values |
| evtIn | input | NUM_FLAGS | Per-flag event pulses from the timer |
| dmaAck | input | 1 | DMA transfer acknowledge for one flag |
| dmaIdx | input | IDX_W | Index of the flag that triggered the DMA transfer |
| dmaSrcAddr | input | ADDR_W | Source address of the DMA transfer |
| dmaDstAddr | input | ADDR_W | Destination address of the DMA transfer |
| irqOut | output | NUM_FLAGS | Interrupt request per flag, high while the flag is set |

## Verification
The assertions assume that `dmaIdx` always selects an existing flag and that the event, bus and DMA inputs carry known values in every cycle after reset. They do not assume that reads and writes are separate, but the bench never raises `busRead` and `busWrite` in the same cycle, because the requirements do not define what happens when both arrive together. The random stimulus takes DMA addresses from a small set that includes both window bounds and the addresses just outside them. It also weights write data towards zeros, so that arm, block and clear sequences happen often.

// File: rtl/isr_pkg.sv
package isr_pkg;
  // Bus address width seen on the DMA acknowledge.
  parameter int ADDR_W = 32;

  // Strobes decoded by the control and consumed by the flag datapath.
  typedef struct packed {
    logic rdStb;   // register read, arms set bits
    logic wrStb;   // register write, clear attempt and disarm
    logic dmaClr;  // DMA acknowledge whose address hits the window
  } isrStrobe_t;
endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl #(
  parameter int NUM_FLAGS = 16,
  parameter int IDX_W = $clog2(NUM_FLAGS),
  parameter logic [isr_pkg::ADDR_W-1:0] WIN_BASE = 32'hFFFF8200,
  parameter logic [isr_pkg::ADDR_W-1:0] WIN_LAST = 32'hFFFF82FF
) (
  input  logic                       busRead,
  input  logic                       busWrite,
  input  logic                       dmaAck,
  input  logic [IDX_W-1:0]           dmaIdx,
  input  logic [isr_pkg::ADDR_W-1:0] dmaSrcAddr,
  input  logic [isr_pkg::ADDR_W-1:0] dmaDstAddr,
  output isr_pkg::isrStrobe_t        stb,
  output logic [NUM_FLAGS-1:0]       dmaSel
);
  localparam int NUM_PORTS = 2;

  logic [isr_pkg::ADDR_W-1:0] addrList [NUM_PORTS];
  logic [NUM_PORTS-1:0]       addrHit;

  assign addrList[0] = dmaSrcAddr;
  assign addrList[1] = dmaDstAddr;

  // One window comparator for each end of the transfer.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_win
    assign addrHit[p] = (addrList[p] >= WIN_BASE) && (addrList[p] <= WIN_LAST);
  end

  always_comb begin
    stb.rdStb  = busRead;
    stb.wrStb  = busWrite;
    stb.dmaClr = dmaAck && (|addrHit);
  end

  // Decode the DMA flag index to a one-hot select.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sel
    assign dmaSel[i] = (dmaIdx == IDX_W'(i));
  end
endmodule

// File: rtl/isr_flag_dp.sv
module isr_flag_dp #(
  parameter int NUM_FLAGS = 16,
  parameter logic [NUM_FLAGS-1:0] RETRY_MASK = 16'hFF00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  isr_pkg::isrStrobe_t  stb,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic [NUM_FLAGS-1:0] evtIn,
  input  logic [NUM_FLAGS-1:0] dmaSel,
  output logic [NUM_FLAGS-1:0] flagQ
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    logic flag;
    logic armed;
    logic blocked;
    logic dmaHit;
    logic busClr;
    logic clrNow;

    assign dmaHit = stb.dmaClr && dmaSel[i];
    // A write of 0 clears only an armed bit that has not been blocked.
    assign busClr = stb.wrStb && !wrData[i] && armed && !blocked;
    assign clrNow = busClr || dmaHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flag  <= 1'b0;
        armed <= 1'b0;
      end else begin
        // An event in the same cycle as a clear keeps the flag set.
        flag <= (flag && !clrNow) || evtIn[i];
        if (dmaHit || stb.wrStb) armed <= 1'b0;
        else if (stb.rdStb)      armed <= flag;
      end
    end

    if (RETRY_MASK[i]) begin : g_retry
      // An event while the bit is armed spoils the pending clear.
      always_ff @(posedge clk) begin
        if (!rstN) blocked <= 1'b0;
        else if (dmaHit || stb.wrStb || stb.rdStb) blocked <= 1'b0;
        else if (armed && evtIn[i]) blocked <= 1'b1;
      end
    end else begin : g_plain
      assign blocked = 1'b0;
    end

    assign flagQ[i] = flag;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_FLAGS = 16,
  parameter int IDX_W = $clog2(NUM_FLAGS),
  parameter logic [NUM_FLAGS-1:0] RETRY_MASK = 16'hFF00,
  parameter logic [isr_pkg::ADDR_W-1:0] WIN_BASE = 32'hFFFF8200,
  parameter logic [isr_pkg::ADDR_W-1:0] WIN_LAST = 32'hFFFF82FF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busRead,
  input  logic                       busWrite,
  input  logic [NUM_FLAGS-1:0]       busWdata,
  output logic [NUM_FLAGS-1:0]       busRdata,
  input  logic [NUM_FLAGS-1:0]       evtIn,
  input  logic                       dmaAck,
  input  logic [IDX_W-1:0]           dmaIdx,
  input  logic [isr_pkg::ADDR_W-1:0] dmaSrcAddr,
  input  logic [isr_pkg::ADDR_W-1:0] dmaDstAddr,
  output logic [NUM_FLAGS-1:0]       irqOut
);
  isr_pkg::isrStrobe_t  stb;
  logic [NUM_FLAGS-1:0] dmaSel;
  logic [NUM_FLAGS-1:0] flagQ;

  isr_ctrl #(
    .NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W),
    .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
  ) u_ctrl (
    .busRead(busRead), .busWrite(busWrite), .dmaAck(dmaAck), .dmaIdx(dmaIdx),
    .dmaSrcAddr(dmaSrcAddr), .dmaDstAddr(dmaDstAddr),
    .stb(stb), .dmaSel(dmaSel)
  );

  isr_flag_dp #(
    .NUM_FLAGS(NUM_FLAGS), .RETRY_MASK(RETRY_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .evtIn(evtIn), .dmaSel(dmaSel), .flagQ(flagQ)
  );

  assign busRdata = flagQ;
  assign irqOut   = flagQ;
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
  parameter int NUM_FLAGS = 16,
  parameter int IDX_W = $clog2(NUM_FLAGS),
  parameter logic [isr_pkg::ADDR_W-1:0] WIN_BASE = 32'hFFFF8200,
  parameter logic [isr_pkg::ADDR_W-1:0] WIN_LAST = 32'hFFFF82FF
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busWrite,
  input logic [NUM_FLAGS-1:0]       busWdata,
  input logic [NUM_FLAGS-1:0]       evtIn,
  input logic                       dmaAck,
  input logic [IDX_W-1:0]           dmaIdx,
  input logic [isr_pkg::ADDR_W-1:0] dmaSrcAddr,
  input logic [isr_pkg::ADDR_W-1:0] dmaDstAddr,
  input logic [NUM_FLAGS-1:0]       irqOut
);
  logic winHit;
  assign winHit = ((dmaSrcAddr >= WIN_BASE) && (dmaSrcAddr <= WIN_LAST)) ||
                  ((dmaDstAddr >= WIN_BASE) && (dmaDstAddr <= WIN_LAST));

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((irqOut & $past(evtIn)) == $past(evtIn)));

  // R3
  only_evt_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((irqOut & ~$past(irqOut) & ~$past(evtIn)) == '0));

  // R11
  no_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && !(dmaAck && winHit)) |=> (($past(irqOut) & ~irqOut) == '0));

  // R3
  one_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !dmaAck) |=> (($past(irqOut) & $past(busWdata) & ~irqOut) == '0));

  // R10
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && winHit && !evtIn[dmaIdx]) |=> !irqOut[$past(dmaIdx)]);
endmodule

bind irq_status_bank irq_status_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busWdata(busWdata),
  .evtIn(evtIn), .dmaAck(dmaAck), .dmaIdx(dmaIdx),
  .dmaSrcAddr(dmaSrcAddr), .dmaDstAddr(dmaDstAddr), .irqOut(irqOut)
);

// File: tb/irq_status_bank_tb.sv
module irq_status_bank_tb;
  localparam int N = 16;
  localparam logic [N-1:0] RETRY = 16'hFF00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRead = 1'b0, busWrite = 1'b0, dmaAck = 1'b0;
  logic [N-1:0] busWdata = '0, evtIn = '0;
  logic [3:0] dmaIdx = '0;
  logic [31:0] dmaSrcAddr = '0, dmaDstAddr = '0;
  logic [N-1:0] busRdata, irqOut;

  int checks = 0, errors = 0;
  logic [N-1:0] mFlag = '0, mArm = '0, mBlk = '0;

  always #4 clk = ~clk;  // 125 MHz

  irq_status_bank u_dut (
    .clk(clk), .rstN(rstN), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .dmaAck(dmaAck),
    .dmaIdx(dmaIdx), .dmaSrcAddr(dmaSrcAddr), .dmaDstAddr(dmaDstAddr), .irqOut(irqOut)
  );

  function automatic logic inWin(logic [31:0] a);
    return (a >= 32'hFFFF8200) && (a <= 32'hFFFF82FF);
  endfunction

  function automatic logic [31:0] pickAddr(int k);
    case (k % 6)
      0: return 32'hFFFF8200;
      1: return 32'hFFFF82FF;
      2: return 32'hFFFF81FF;
      3: return 32'hFFFF8300;
      4: return 32'hFFFF8280;
      default: return 32'h0000_1000;
    endcase
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, update the reference, return at the next negedge.
  task automatic step(logic rd, logic wr, logic [N-1:0] wd, logic [N-1:0] ev,
                      logic dma, logic [3:0] idx, logic [31:0] src, logic [31:0] dst);
    logic [N-1:0] clr, nArm, nBlk, sel;
    busRead = rd; busWrite = wr; busWdata = wd; evtIn = ev;
    dmaAck = dma; dmaIdx = idx; dmaSrcAddr = src; dmaDstAddr = dst;
    sel = (dma && (inWin(src) || inWin(dst))) ? (N'(1) << idx) : '0;
    clr = (wr ? (~wd & mArm & ~(mBlk & RETRY)) : '0) | sel;
    nArm = wr ? '0 : (rd ? mFlag : mArm);
    nBlk = (wr || rd) ? '0 : (mBlk | (mArm & ev));
    mFlag = (mFlag & ~clr) | ev;
    mArm = nArm & ~sel;
    mBlk = nBlk & ~sel;
    @(posedge clk);
    @(negedge clk);
    busRead = 0; busWrite = 0; evtIn = '0; dmaAck = 0;
  endtask

  task automatic idle();       step(0, 0, '0, '0, 0, 0, 0, 0); endtask
  task automatic rdReg();      step(1, 0, '0, '0, 0, 0, 0, 0); endtask
  task automatic wrReg(logic [N-1:0] d); step(0, 1, d, '0, 0, 0, 0, 0); endtask
  task automatic evt(logic [N-1:0] e);   step(0, 0, '0, e, 0, 0, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset rdata", busRdata, '0);
    chk("R1 reset irq", irqOut, '0);

    evt(16'h0408);
    chk("R2 events set", irqOut, 16'h0408);
    chk("R2 rdata shows flags", busRdata, 16'h0408);
    evt(16'h0008);
    chk("R2 repeat event", irqOut, 16'h0408);

    wrReg(16'h0000);
    chk("R4 write0 without read", irqOut, 16'h0408);
    wrReg(16'hFFFF);
    chk("R3 write1 no effect", irqOut, 16'h0408);

    rdReg(); wrReg(16'hFFF7);
    chk("R5 read then write0", irqOut, 16'h0400);

    rdReg(); evt(16'h0400); wrReg(16'h0000);
    chk("R6 retry blocked", irqOut, 16'h0400);
    rdReg(); wrReg(16'h0000);
    chk("R6 retry reread clears", irqOut, 16'h0000);

    evt(16'h0004); rdReg(); evt(16'h0004); wrReg(16'h0000);
    chk("R7 plain not blocked", irqOut, 16'h0000);

    evt(16'h0020); rdReg(); wrReg(16'hFFFF); wrReg(16'h0000);
    chk("R8 arm used by write", irqOut, 16'h0020);
    rdReg(); wrReg(16'h0000);
    chk("R8 cleanup", irqOut, 16'h0000);

    evt(16'h0010); rdReg(); step(0, 1, 16'h0000, 16'h0010, 0, 0, 0, 0);
    chk("R9 event beats write clear", irqOut, 16'h0010);
    step(0, 0, '0, 16'h0010, 1, 4'd4, 32'hFFFF8200, 0);
    chk("R9 event beats dma clear", irqOut, 16'h0010);

    step(0, 0, '0, '0, 1, 4'd4, 32'hFFFF82FF, 32'h0);
    chk("R10 dma src upper bound", irqOut, 16'h0000);
    evt(16'h0080); step(0, 0, '0, '0, 1, 4'd7, 32'h0, 32'hFFFF8200);
    chk("R10 dma dst lower bound", irqOut, 16'h0000);
    evt(16'h0080); rdReg(); step(0, 0, '0, '0, 1, 4'd7, 32'hFFFF8280, 32'h0);
    evt(16'h0080); wrReg(16'h0000);
    chk("R10 dma disarms", irqOut, 16'h0080);

    step(0, 0, '0, '0, 1, 4'd7, 32'hFFFF8300, 32'hFFFF81FF);
    chk("R11 dma outside window", irqOut, 16'h0080);
    rdReg(); wrReg(16'h0000);
    chk("R11 cleanup", irqOut, 16'h0000);

    // Random phase: reads and writes never share a cycle.
    for (int c = 0; c < 1500; c++) begin
      int r = $urandom % 8;
      logic [N-1:0] ev = ($urandom % 4 == 0) ? (N'(1) << ($urandom % N)) : '0;
      logic dma = ($urandom % 6 == 0);
      step(r < 2, (r == 2 || r == 3), N'($urandom & $urandom), ev, dma,
           4'($urandom % N), pickAddr($urandom), pickAddr($urandom));
      chk("R2-model irq", irqOut, mFlag);
      chk("R5-model rdata", busRdata, mFlag);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule